// File: doc/BRIEF.md
# Per-Line Debounce Filter Bank

This block sits between the input pads of the external interrupt lines and the interrupt detection logic. Each line first passes through a two-stage synchroniser. On the lowest-numbered lines, the first `NUM_DB` of them, a stability filter can then be switched in. When the filter is active, a new input level reaches the interrupt logic only after it has held steady for a chosen number of slow ticks. Short glitches never get through. The filter is active only while the line is enabled for filtering and the interrupt logic reports that the line is level-sensitive. Otherwise the synchronised level passes straight through.

Software configures each filtered line through one byte of a 32-bit control word. That byte holds an enable bit, a restart bit and a four-bit period code. The words can be read and written directly, or changed through write-one-to-set and write-one-to-clear aliases so that neighbouring lines are left alone. When the interrupt logic finishes servicing a filtered line, it pulses a service input, and the line's stability count starts over.

Top module: `line_debounce_bank`

## Requirements
- R1: Line n owns byte (n%4) of control word n/4. In that byte, bit 0 is enable, bits 7:4 are the period code, and bits 3:1 always read 0. Word w reads back, and is written in full, at byte address 0x500 + 4w. The bus read data is 0 at any other address.
- R2: A write to 0x600 + 4w sets every enable and code bit that is 1 in the data. A write to 0x700 + 4w clears them. All other bits keep their value.
- R3: Bit 1 of a field is a restart command. Writing it as 1 through either the 0x500 or the 0x600 address makes the line's stability count start from zero within two clock cycles. The bit always reads back as 0.
- R4: While the filter is active, the output takes a new level only after the synchronised input has differed from the output for the selected number of ticks without interruption. A pulse shorter than that leaves the output unchanged.
- R5: One tick occurs every `TICK_DIV` clock cycles. The period code maps to a tick count as follows: code 0 is 1 tick, code 1 is 2 ticks, codes k from 2 to 6 are 2^(k+3) ticks, and codes 7 to 15 all give 512 ticks.
- R6: With enable at 0, the output equals the line input delayed by two clock cycles.
- R7: With `level_sens` at 0 (edge-sensitive), the output equals the line input delayed by two clock cycles, whatever the line's field holds.
- R8: Lines with index `NUM_DB` or above have no filter. Their fields read 0, writes to them have no effect, and their output is the input delayed by two cycles.
- R9: A one-cycle pulse on `svc_ack[n]` restarts the stability count of line n when its enable bit is 1.
- R10: After reset, every field reads 0 and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | NUM_LINES | Raw external line levels |
| level_sens | input | NUM_LINES | 1 = the line is level-sensitive, so filtering is allowed |
| svc_ack | input | NUM_LINES | One-cycle pulse marking that a line's interrupt was serviced |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| line_out | output | NUM_LINES | Filtered or passed-through levels |

## Verification
The hardest case to reach is a restart in the middle of a count, through either the restart bit or the service pulse. No port shows the stability counter directly. The bench flips a line, lets about half of the period go by, and then issues the restart. It then measures how many cycles remain until the output moves. A restart that is ignored or taken late shows up as a remaining time clearly shorter than one full period. The period ladder is swept over all sixteen codes on one line, and each measured latency is checked against a window derived from the code and the tick divider.

// File: rtl/dbnc_pkg.sv
// Shared definitions for the debounce filter bank.
// Assumes the fixed 12-bit register address layout described in the brief.
package dbnc_pkg;
    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int CODE_W  = 4;
    localparam int LIM_W   = 10;   // holds the longest period, 512 ticks
    localparam logic [3:0] RGN_VAL = 4'h5;
    localparam logic [3:0] RGN_SET = 4'h6;
    localparam logic [3:0] RGN_CLR = 4'h7;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              en;
    } dbnc_cfg_t;

    // Map a period code to the number of ticks the input must stay stable.
    function automatic logic [LIM_W:0] code_to_ticks(input logic [CODE_W-1:0] c);
        logic [LIM_W:0] t;
        if (c == 4'd0)      t = 11'd1;
        else if (c == 4'd1) t = 11'd2;
        else if (c <= 4'd6) t = 11'(1) << (c + 4'd3);
        else                t = 11'd512;
        return t;
    endfunction
endpackage

// File: rtl/dbnc_tick.sv
// Prescaler: emits a one-cycle tick every DIV clock cycles.
// Assumes DIV >= 1. For DIV == 1 the tick stays high every cycle.
module dbnc_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    // Count cycles and pulse the tick when the count wraps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q  <= '0;
            tick_o <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            tick_o <= 1'b0;
        end
    end
endmodule

// File: rtl/dbnc_regs.sv
// Control register file: one byte per line, with value, set and clear aliases.
// Assumes NUM_DB <= NUM_LINES and at most 64 words. Reads are combinational.
module dbnc_regs
    import dbnc_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int NUM_DB    = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    input  logic [NUM_LINES-1:0]  svc_ack,
    output logic [DATA_W-1:0]     bus_rdata,
    output dbnc_cfg_t             cfg_o     [NUM_LINES],
    output logic [NUM_LINES-1:0]  restart_o
);
    localparam int WORDS = (NUM_LINES + 3) / 4;
    localparam int PAD   = WORDS * 4;

    logic [3:0] region;
    logic [5:0] widx;
    logic       aligned;
    logic [WORDS-1:0][DATA_W-1:0] rd_word;

    assign region  = bus_addr[11:8];
    assign widx    = bus_addr[7:2];
    assign aligned = (bus_addr[1:0] == 2'b00);

    for (genvar i = 0; i < PAD; i++) begin : g_fld
        localparam int W = i / 4;
        localparam int B = (i % 4) * 8;
        if (i < NUM_DB) begin : g_live
            dbnc_cfg_t  cfg_q;
            logic       rs_q;
            logic [7:0] fld;
            logic       hit;
            assign fld = bus_wdata[B +: 8];
            assign hit = bus_wr && aligned && (widx == 6'(W));

            // Update the field from the bus and raise the one-cycle restart.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cfg_q <= '0;
                    rs_q  <= 1'b0;
                end else begin
                    rs_q <= svc_ack[i] && cfg_q.en;
                    if (hit) begin
                        case (region)
                            RGN_VAL: begin
                                cfg_q.en   <= fld[0];
                                cfg_q.code <= fld[7:4];
                                if (fld[1]) rs_q <= 1'b1;
                            end
                            RGN_SET: begin
                                cfg_q.en   <= cfg_q.en | fld[0];
                                cfg_q.code <= cfg_q.code | fld[7:4];
                                if (fld[1]) rs_q <= 1'b1;
                            end
                            RGN_CLR: begin
                                cfg_q.en   <= cfg_q.en & ~fld[0];
                                cfg_q.code <= cfg_q.code & ~fld[7:4];
                            end
                            default: ;
                        endcase
                    end
                end
            end

            assign rd_word[W][B +: 8] = {cfg_q.code, 3'b000, cfg_q.en};
            assign cfg_o[i]     = cfg_q;
            assign restart_o[i] = rs_q;
        end else begin : g_none
            assign rd_word[W][B +: 8] = 8'h00;
            if (i < NUM_LINES) begin : g_tie
                assign cfg_o[i]     = '0;
                assign restart_o[i] = svc_ack[i];
            end
        end
    end

    // Select the addressed control word for a read of the value region.
    always_comb begin
        bus_rdata = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (region == RGN_VAL && aligned && widx == 6'(w))
                bus_rdata = rd_word[w];
        end
    end
endmodule

// File: rtl/dbnc_line.sv
// One line: two-stage synchroniser followed by a tick-counted stability filter.
// Assumes tick_i is a one-cycle pulse. When the filter is inactive the output
// equals the synchronised input, and the held level tracks it so that
// switching the filter on causes no glitch.
module dbnc_line
    import dbnc_pkg::*;
#(
    parameter bit ELIG = 1'b1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      raw_i,
    input  logic      level_i,
    input  dbnc_cfg_t cfg_i,
    input  logic      restart_i,
    input  logic      tick_i,
    output logic      out_o,
    output logic      act_o
);
    logic [1:0]       sy_q;
    logic             s;
    logic             held_q;
    logic [LIM_W-1:0] cnt_q;
    logic [LIM_W:0]   lim;
    logic [LIM_W:0]   nxt;

    assign s     = sy_q[1];
    assign act_o = ELIG && cfg_i.en && level_i;
    assign lim   = code_to_ticks(cfg_i.code);
    assign nxt   = {1'b0, cnt_q} + 1'b1;

    // Bring the raw level into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sy_q <= 2'b00;
        else        sy_q <= {sy_q[0], raw_i};
    end

    // Count ticks while the input differs from the held level; accept it at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!act_o) begin
            held_q <= s;
            cnt_q  <= '0;
        end else if (restart_i || s == held_q) begin
            cnt_q  <= '0;
        end else if (tick_i) begin
            if (nxt >= lim) begin
                held_q <= s;
                cnt_q  <= '0;
            end else begin
                cnt_q  <= nxt[LIM_W-1:0];
            end
        end
    end

    assign out_o = act_o ? held_q : s;
endmodule

// File: rtl/line_debounce_bank.sv
// Top: shared tick prescaler, control register file and one filter per line.
// Assumes line_in is asynchronous. Only lines below NUM_DB can be filtered.
module line_debounce_bank
    import dbnc_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int NUM_DB    = 6,
    parameter int TICK_DIV  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_in,
    input  logic [NUM_LINES-1:0] level_sens,
    input  logic [NUM_LINES-1:0] svc_ack,
    input  logic                 bus_wr,
    input  logic [11:0]          bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [NUM_LINES-1:0] line_out
);
    logic                 tick_w;
    dbnc_cfg_t            cfg_w [NUM_LINES];
    logic [NUM_LINES-1:0] restart_w;
    logic [NUM_LINES-1:0] act_w;

    dbnc_tick #(.DIV(TICK_DIV)) tick_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick_w)
    );

    dbnc_regs #(.NUM_LINES(NUM_LINES), .NUM_DB(NUM_DB)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .svc_ack   (svc_ack),
        .bus_rdata (bus_rdata),
        .cfg_o     (cfg_w),
        .restart_o (restart_w)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        dbnc_line #(.ELIG(i < NUM_DB)) line_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .raw_i     (line_in[i]),
            .level_i   (level_sens[i]),
            .cfg_i     (cfg_w[i]),
            .restart_i (restart_w[i]),
            .tick_i    (tick_w),
            .out_o     (line_out[i]),
            .act_o     (act_w[i])
        );
    end
endmodule

// File: rtl/line_debounce_bank_chk.sv
// Checker for the debounce bank, attached by bind.
// Assumes the bind connects the internal tick and filter-active vectors.
module line_debounce_bank_chk #(
    parameter int NUM_LINES = 8,
    parameter int NUM_DB    = 6,
    parameter int TICK_DIV  = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tick,
    input logic [NUM_LINES-1:0] act,
    input logic [NUM_LINES-1:0] line_in,
    input logic [NUM_LINES-1:0] line_out,
    input logic [31:0]          bus_rdata
);
    logic [1:0] settle_q;

    // Count clock edges since reset was released, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)                settle_q <= 2'd0;
        else if (settle_q != 2'd3) settle_q <= settle_q + 2'd1;
    end

    // R3: the restart bit and the reserved bits never read back as 1
    p_rd_rst_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & 32'h0E0E0E0E) == 32'h0);

    if (TICK_DIV > 1) begin : g_tk
        // R5: ticks are isolated single-cycle pulses
        p_tick_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_ln
        if (i < NUM_DB) begin : g_f
            // R4: an active filter changes its output only on a tick
            p_filt_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (settle_q != 2'd0 && act[i] && $past(act[i]) &&
                 line_out[i] != $past(line_out[i])) |-> $past(tick));
        end else begin : g_b
            // R8: lines without a filter follow the input two cycles later
            p_bypass_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (settle_q >= 2'd2) |-> line_out[i] == $past(line_in[i], 2));
        end
    end
endmodule

bind line_debounce_bank line_debounce_bank_chk #(
    .NUM_LINES (NUM_LINES),
    .NUM_DB    (NUM_DB),
    .TICK_DIV  (TICK_DIV)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_w),
    .act       (act_w),
    .line_in   (line_in),
    .line_out  (line_out),
    .bus_rdata (bus_rdata)
);

// File: tb/line_debounce_bank_tb_top.sv
`timescale 1ns/1ps
module line_debounce_bank_tb_top;
    localparam int NL = 8;
    localparam int ND = 6;
    localparam int D  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] line_in = '0;
    logic [NL-1:0] level_sens = '1;
    logic [NL-1:0] svc_ack = '0;
    logic          bus_wr = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NL-1:0] line_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    line_debounce_bank #(.NUM_LINES(NL), .NUM_DB(ND), .TICK_DIV(D)) dut_i (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .level_sens(level_sens),
        .svc_ack(svc_ack), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .line_out(line_out)
    );

    function automatic int exp_lim(input int code);
        if (code == 0) return 1;
        if (code == 1) return 2;
        if (code <= 6) return 1 << (code + 3);
        return 512;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic set_field(input int ln, input int code, input bit en);
        logic [11:0] off;
        int sh;
        off = 12'((ln / 4) * 4);
        sh  = (ln % 4) * 8;
        wr(12'h700 + off, 32'hFF << sh);
        wr(12'h600 + off, {24'h0, 4'(code), 3'b000, en} << sh);
    endtask

    // Count cycles until the output of line ln matches its input.
    task automatic wait_match(input int ln, input int maxc, output int lat);
        lat = -1;
        for (int c = 1; c <= maxc && lat < 0; c++) begin
            @(posedge clk); #1;
            if (line_out[ln] == line_in[ln]) lat = c;
        end
    endtask

    task automatic flip_measure(input int ln, input int maxc, output int lat);
        @(negedge clk);
        line_in[ln] = ~line_in[ln];
        wait_match(ln, maxc, lat);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int lat, lo, hi, lim;
        bit moved;
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R10: reset state
        rd(12'h500, d); check(d == 0, "R10 word0", d, 0);
        rd(12'h504, d); check(d == 0, "R10 word1", d, 0);
        check(line_out == 0, "R10 outputs", line_out, 0);

        // R1 / R3: value register masks to enable and code, restart reads 0
        wr(12'h500, 32'h12345678);
        rd(12'h500, d); check(d == 32'h10305070, "R1 value rw", d, 32'h10305070);
        rd(12'h400, d); check(d == 0, "R1 other address", d, 0);
        // R2: set and clear aliases
        wr(12'h600, 32'h00000101);
        rd(12'h500, d); check(d == 32'h10305171, "R2 set alias", d, 32'h10305171);
        wr(12'h700, 32'h10000070);
        rd(12'h500, d); check(d == 32'h00305101, "R2 clear alias", d, 32'h00305101);
        wr(12'h600, 32'h02020202);
        rd(12'h500, d); check(d == 32'h00305101, "R3 restart bit reads 0", d, 32'h00305101);

        // R8: fields of unfiltered lines read 0 and ignore writes
        wr(12'h504, 32'hFFFFFFFF);
        rd(12'h504, d); check(d == 32'h0000F1F1, "R8 upper fields", d, 32'h0000F1F1);
        wr(12'h500, 32'h0); wr(12'h504, 32'h0);
        flip_measure(6, 20, lat);
        check(lat == 2, "R8 bypass latency", lat, 2);

        // R4 / R5: sweep every code on line 0
        for (int code = 0; code < 16; code++) begin
            set_field(0, code, 1'b1);
            lim = exp_lim(code);
            lo = (lim - 1) * D + 1;
            hi = lim * D + 3;
            flip_measure(0, hi + 20, lat);
            check(lat >= lo && lat <= hi, $sformatf("R5 code %0d latency", code), lat, lim * D);
        end

        // R4: a pulse shorter than the period is suppressed
        set_field(1, 2, 1'b1);
        moved = 0;
        @(negedge clk); line_in[1] = 1'b1;
        for (int c = 0; c < 60; c++) begin @(negedge clk); if (line_out[1]) moved = 1; end
        line_in[1] = 1'b0;
        for (int c = 0; c < 200; c++) begin @(negedge clk); if (line_out[1]) moved = 1; end
        check(!moved, "R4 glitch suppressed", moved, 0);

        // R3: restart through the set alias halfway through a count
        set_field(2, 3, 1'b1);
        lim = exp_lim(3);
        @(negedge clk); line_in[2] = 1'b1;
        repeat (150) @(negedge clk);
        wr(12'h600, 32'h1 << 17);
        wait_match(2, lim * D + 40, lat);
        check(lat >= (lim - 1) * D - 2 && lat <= lim * D + 5, "R3 restart delays output", lat, lim * D);
        rd(12'h500, d); check(d[23:16] == 8'h31, "R3 field after restart", d[23:16], 8'h31);

        // R9: a service pulse restarts the count
        set_field(3, 3, 1'b1);
        @(negedge clk); line_in[3] = 1'b1;
        repeat (150) @(negedge clk);
        svc_ack[3] = 1'b1;
        @(negedge clk); svc_ack[3] = 1'b0;
        wait_match(3, lim * D + 40, lat);
        check(lat >= (lim - 1) * D - 2 && lat <= lim * D + 5, "R9 service restart", lat, lim * D);

        // R6: a disabled line passes through
        set_field(4, 6, 1'b0);
        flip_measure(4, 20, lat);
        check(lat == 2, "R6 disabled bypass", lat, 2);

        // R7: an edge-sensitive line passes through even when enabled
        set_field(5, 6, 1'b1);
        level_sens[5] = 1'b0;
        flip_measure(5, 20, lat);
        check(lat == 2, "R7 edge-sensitive bypass", lat, 2);
        flip_measure(5, 20, lat);
        check(lat == 2, "R7 edge-sensitive bypass fall", lat, 2);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule